// File: doc/BRIEF.md
# Component Colour-Difference to RGB Matrix

This block turns a stream of 8-bit luma and colour-difference samples into 8-bit red, green and blue, one pixel on every clock. The luma input is taken as bottom-referenced, so code 0 is black. Both colour-difference inputs are referenced to mid-scale, so code 128 means no colour. The block removes that mid-scale offset, then applies a fixed high-definition matrix with signed fixed-point coefficients. Each sum is rounded to the nearest integer and clipped to the 8-bit range.

A bypass input lets pixels that are already RGB through unchanged, with the same delay as converted pixels. The display-timing sideband (data enable, horizontal sync, vertical sync) travels through a delay line of the same length, so the sideband always stays aligned with the pixel it came with. The block drives flat-panel or DAC timing directly. The host can change bypass on any pixel.

The datapath has two register stages. The first stage removes the offset and forms the products. The second stage adds the terms, rounds, saturates and registers the output. There is no control state machine. The only state is the pipeline registers, and each is cleared by a synchronous active-low reset.

Top module: `ypbpr_rgb_conv`

## Requirements
- R1: Pixel data appears on the outputs exactly two clock edges after it is sampled at the inputs, in both conversion and bypass.
- R2: out_de, out_hs and out_vs equal in_de, in_hs and in_vs as sampled two edges earlier.
- R3: With bypass low, out_r = clip(floor((4096·Y + 6451·(Pr−128) + 2048) / 4096)), where Y is in_y_g and Pr is in_pr_r.
- R4: With bypass low, out_g = clip(floor((4096·Y − 1917·(Pr−128) − 766·(Pb−128) + 2048) / 4096)), where Pb is in_pb_b.
- R5: With bypass low, out_b = clip(floor((4096·Y + 7602·(Pb−128) + 2048) / 4096)).
- R6: With bypass low and both colour-difference inputs at 128, all three outputs equal Y.
- R7: Results are rounded to nearest with halves rounded up. This is the +2048 term with a floor division by 4096, including for negative intermediate sums.
- R8: clip() gives 0 for any negative result and 255 for any result above 255. For example, Y=255 with Pr≥128 gives out_r=255, and Y=0 with Pb≤128 gives out_b=0.
- R9: With bypass high, out_r = in_pr_r, out_g = in_y_g and out_b = in_pb_b, all taken from two edges earlier. Bypass is pipelined with the pixel, so it may change on any cycle.
- R10: While rst_n is low at a clock edge, all six outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bypass | input | 1 | High: pass the inputs through as R/G/B |
| in_y_g | input | 8 | Luma, or green in bypass |
| in_pb_b | input | 8 | Blue difference (offset 128), or blue in bypass |
| in_pr_r | input | 8 | Red difference (offset 128), or red in bypass |
| in_de | input | 1 | Data enable sideband |
| in_hs | input | 1 | Horizontal sync sideband |
| in_vs | input | 1 | Vertical sync sideband |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
The bound checker checks the following on every cycle:
- the two-cycle alignment of the sideband bits;
- pass-through under bypass;
- the neutral-chroma identity;
- the two saturation rails;
- the clearing on reset.

The exact matrix values and the rounding of negative intermediate sums can only be shown by the bench's sweeps, which compare against arithmetic expectations. The bench sweeps Pr across all codes, sweeps Pb across all codes, sweeps Y over the neutral axis, and toggles bypass per pixel.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PIX_W     = 8;
    localparam int COEF_FRAC = 12;
    localparam int PIPE_LAT  = 2;
    // Matrix coefficients scaled by 2**COEF_FRAC
    localparam int K_R_PR    = 6451;
    localparam int K_G_PR    = -1917;
    localparam int K_G_PB    = -766;
    localparam int K_B_PB    = 7602;
    localparam int NUM_CH    = 3;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } sideband_t;
endpackage

// File: rtl/csc_sideband_delay.sv
module csc_sideband_delay #(
    parameter int DEPTH = 2,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= '0;
                    else        stage_q[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= '0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/csc_chan.sv
// One output channel: result = luma + KA*(diff_a-mid) + KB*(diff_b-mid),
// rounded to nearest and clipped; or pass_val when bypassed.
module csc_chan #(
    parameter int PIX_W = 8,
    parameter int FRAC  = 12,
    parameter int KA    = 0,
    parameter int KB    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] luma,
    input  logic [PIX_W-1:0] diff_a,
    input  logic [PIX_W-1:0] diff_b,
    input  logic             bypass,
    input  logic [PIX_W-1:0] pass_val,
    output logic [PIX_W-1:0] result
);
    localparam int DW    = PIX_W + 1;
    localparam int ACC_W = PIX_W + FRAC + 4;
    localparam int MID   = 1 << (PIX_W - 1);
    localparam int MAXV  = (1 << PIX_W) - 1;
    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1 << (FRAC - 1));
    localparam logic signed [ACC_W-1:0] KA_S  = ACC_W'(KA);
    localparam logic signed [ACC_W-1:0] KB_S  = ACC_W'(KB);
    localparam logic signed [ACC_W-1:0] TOP_S = ACC_W'(MAXV);

    // ---------------- stage 1: offset removal and products ----------------
    logic signed [DW-1:0]    da_c, db_c;
    logic signed [ACC_W-1:0] da_x, db_x;
    logic signed [ACC_W-1:0] base_c, pa_c, pb_c;

    assign da_c   = $signed({1'b0, diff_a}) - $signed(DW'(MID));
    assign db_c   = $signed({1'b0, diff_b}) - $signed(DW'(MID));
    assign da_x   = $signed({{(ACC_W-DW){da_c[DW-1]}}, da_c});
    assign db_x   = $signed({{(ACC_W-DW){db_c[DW-1]}}, db_c});
    assign base_c = $signed({{(ACC_W-PIX_W-FRAC){1'b0}}, luma, {FRAC{1'b0}}}) + HALF;
    assign pa_c   = KA_S * da_x;
    assign pb_c   = KB_S * db_x;

    logic signed [ACC_W-1:0] base_q, pa_q, pb_q;
    logic                    byp_q;
    logic [PIX_W-1:0]        pass_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            pa_q   <= '0;
            pb_q   <= '0;
            byp_q  <= 1'b0;
            pass_q <= '0;
        end else begin
            base_q <= base_c;
            pa_q   <= pa_c;
            pb_q   <= pb_c;
            byp_q  <= bypass;
            pass_q <= pass_val;
        end
    end

    // ---------------- stage 2: sum, round, clip ----------------
    logic signed [ACC_W-1:0] sum_c, shr_c;
    logic [PIX_W-1:0]        clip_c;

    assign sum_c = base_q + pa_q + pb_q;
    assign shr_c = sum_c >>> FRAC;

    always_comb begin
        if (sum_c[ACC_W-1])      clip_c = '0;
        else if (shr_c > TOP_S)  clip_c = PIX_W'(MAXV);
        else                     clip_c = shr_c[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= byp_q ? pass_q : clip_c;
    end
endmodule

// File: rtl/ypbpr_rgb_conv.sv
module ypbpr_rgb_conv
    import csc_pkg::*;
#(
    parameter int P_W    = PIX_W,
    parameter int P_FRAC = COEF_FRAC,
    parameter int P_R_PR = K_R_PR,
    parameter int P_G_PR = K_G_PR,
    parameter int P_G_PB = K_G_PB,
    parameter int P_B_PB = K_B_PB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bypass,
    input  logic [P_W-1:0] in_y_g,
    input  logic [P_W-1:0] in_pb_b,
    input  logic [P_W-1:0] in_pr_r,
    input  logic           in_de,
    input  logic           in_hs,
    input  logic           in_vs,
    output logic [P_W-1:0] out_r,
    output logic [P_W-1:0] out_g,
    output logic [P_W-1:0] out_b,
    output logic           out_de,
    output logic           out_hs,
    output logic           out_vs
);
    localparam int KA_T [NUM_CH] = '{P_R_PR, P_G_PR, P_B_PB};
    localparam int KB_T [NUM_CH] = '{0,      P_G_PB, 0};

    logic [P_W-1:0] a_sel    [NUM_CH];
    logic [P_W-1:0] b_sel    [NUM_CH];
    logic [P_W-1:0] pass_sel [NUM_CH];
    logic [P_W-1:0] res      [NUM_CH];

    // channel 0 = red, 1 = green, 2 = blue
    always_comb begin
        a_sel[0] = in_pr_r;  b_sel[0] = in_pr_r;  pass_sel[0] = in_pr_r;
        a_sel[1] = in_pr_r;  b_sel[1] = in_pb_b;  pass_sel[1] = in_y_g;
        a_sel[2] = in_pb_b;  b_sel[2] = in_pb_b;  pass_sel[2] = in_pb_b;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            csc_chan #(
                .PIX_W (P_W),
                .FRAC  (P_FRAC),
                .KA    (KA_T[c]),
                .KB    (KB_T[c])
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .luma     (in_y_g),
                .diff_a   (a_sel[c]),
                .diff_b   (b_sel[c]),
                .bypass   (bypass),
                .pass_val (pass_sel[c]),
                .result   (res[c])
            );
        end
    endgenerate

    assign out_r = res[0];
    assign out_g = res[1];
    assign out_b = res[2];

    sideband_t sb_in, sb_out;
    assign sb_in = '{de: in_de, hs: in_hs, vs: in_vs};

    csc_sideband_delay #(
        .DEPTH (PIPE_LAT),
        .W     ($bits(sideband_t))
    ) u_sb_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sb_in),
        .dout  (sb_out)
    );

    assign out_de = sb_out.de;
    assign out_hs = sb_out.hs;
    assign out_vs = sb_out.vs;
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
    parameter int P_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bypass,
    input logic [P_W-1:0] in_y_g,
    input logic [P_W-1:0] in_pb_b,
    input logic [P_W-1:0] in_pr_r,
    input logic           in_de,
    input logic           in_hs,
    input logic           in_vs,
    input logic [P_W-1:0] out_r,
    input logic [P_W-1:0] out_g,
    input logic [P_W-1:0] out_b,
    input logic           out_de,
    input logic           out_hs,
    input logic           out_vs
);
    localparam logic [P_W-1:0] MIDC = P_W'(1 << (P_W - 1));
    localparam logic [P_W-1:0] MAXC = P_W'((1 << P_W) - 1);

    // counts edges since reset release, saturating at 2
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R2
    sideband_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (out_de == $past(in_de, 2) && out_hs == $past(in_hs, 2)
                            && out_vs == $past(in_vs, 2)));

    // R9
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(bypass, 2)) |->
        (out_r == $past(in_pr_r, 2) && out_g == $past(in_y_g, 2) && out_b == $past(in_pb_b, 2)));

    // R6
    neutral_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !$past(bypass, 2) && $past(in_pb_b, 2) == MIDC && $past(in_pr_r, 2) == MIDC) |->
        (out_r == $past(in_y_g, 2) && out_g == $past(in_y_g, 2) && out_b == $past(in_y_g, 2)));

    // R8
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !$past(bypass, 2) && $past(in_y_g, 2) == MAXC && $past(in_pr_r, 2) >= MIDC) |->
        (out_r == MAXC));

    // R8
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !$past(bypass, 2) && $past(in_y_g, 2) == '0 && $past(in_pb_b, 2) <= MIDC) |->
        (out_b == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_r == '0 && out_g == '0 && out_b == '0 && !out_de && !out_hs && !out_vs));
endmodule

bind ypbpr_rgb_conv csc_checker #(.P_W(P_W)) u_csc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .bypass  (bypass),
    .in_y_g  (in_y_g),
    .in_pb_b (in_pb_b),
    .in_pr_r (in_pr_r),
    .in_de   (in_de),
    .in_hs   (in_hs),
    .in_vs   (in_vs),
    .out_r   (out_r),
    .out_g   (out_g),
    .out_b   (out_b),
    .out_de  (out_de),
    .out_hs  (out_hs),
    .out_vs  (out_vs)
);

// File: tb/ypbpr_rgb_conv_tb.sv
`timescale 1ns/1ps
module ypbpr_rgb_conv_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bypass = 1'b0;
    logic [7:0] in_y_g = '0, in_pb_b = '0, in_pr_r = '0;
    logic       in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic [7:0] out_r, out_g, out_b;
    logic       out_de, out_hs, out_vs;

    always #5 clk = ~clk;

    ypbpr_rgb_conv dut_i (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .in_y_g(in_y_g), .in_pb_b(in_pb_b), .in_pr_r(in_pr_r),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
        .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // history: h0 = applied one step ago, h1 = two steps ago
    bit    h0_v = 0, h1_v = 0;
    int    h0_r, h0_g, h0_b, h1_r, h1_g, h1_b;
    bit    h0_byp, h1_byp;
    bit [2:0] h0_sb, h1_sb;
    string h0_tag, h1_tag;

    function automatic int conv(int y, int a, int b, int ka, int kb);
        int v;
        v = y * 4096 + ka * (a - 128) + kb * (b - 128) + 2048;
        if (v < 0) v = -((-v + 4095) / 4096);
        else       v = v / 4096;
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_old();
        if (h1_v) begin
            if (h1_byp) begin
                check(out_r == h1_r, {"R1,R9 red ", h1_tag}, out_r, h1_r);
                check(out_g == h1_g, {"R1,R9 green ", h1_tag}, out_g, h1_g);
                check(out_b == h1_b, {"R1,R9 blue ", h1_tag}, out_b, h1_b);
            end else begin
                check(out_r == h1_r, {"R1,R3 red ", h1_tag}, out_r, h1_r);
                check(out_g == h1_g, {"R1,R4 green ", h1_tag}, out_g, h1_g);
                check(out_b == h1_b, {"R1,R5 blue ", h1_tag}, out_b, h1_b);
            end
            check({out_de, out_hs, out_vs} == h1_sb, {"R2 sideband ", h1_tag},
                  {out_de, out_hs, out_vs}, h1_sb);
        end
    endtask

    task automatic step(input int y, input int pb, input int pr, input bit byp,
                        input bit [2:0] sb, input string tag);
        @(negedge clk);
        compare_old();
        h1_v = h0_v; h1_r = h0_r; h1_g = h0_g; h1_b = h0_b;
        h1_byp = h0_byp; h1_sb = h0_sb; h1_tag = h0_tag;
        h0_v = 1'b1; h0_byp = byp; h0_sb = sb; h0_tag = tag;
        if (byp) begin
            h0_r = pr; h0_g = y; h0_b = pb;
        end else begin
            h0_r = conv(y, pr, pr, 6451, 0);
            h0_g = conv(y, pr, pb, -1917, -766);
            h0_b = conv(y, pb, pb, 7602, 0);
        end
        in_y_g = 8'(y); in_pb_b = 8'(pb); in_pr_r = 8'(pr);
        bypass = byp;
        {in_de, in_hs, in_vs} = sb;
    endtask

    task automatic flush();
        step(0, 128, 128, 1'b0, 3'b000, "flush");
        step(0, 128, 128, 1'b0, 3'b000, "flush");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        // R10: reset state
        in_y_g = 8'd200; in_pr_r = 8'd77; in_pb_b = 8'd9; {in_de, in_hs, in_vs} = 3'b111;
        repeat (3) @(negedge clk);
        check({out_r, out_g, out_b} == 24'd0, "R10 pixel in reset", {out_r, out_g, out_b}, 0);
        check({out_de, out_hs, out_vs} == 3'd0, "R10 sideband in reset", {out_de, out_hs, out_vs}, 0);
        rst_n = 1'b1;

        // R6: neutral chroma, Y over all codes
        for (int y = 0; y < 256; y++) step(y, 128, 128, 1'b0, 3'(y), "R6 neutral");

        // R3, R4, R7, R8: Pr over all codes, Y sampled, Pb varied
        for (int y = 0; y < 256; y += 17)
            for (int pr = 0; pr < 256; pr++)
                step(y, (pr * 37 + y) % 256, pr, 1'b0, 3'(pr + y), "R7 pr sweep");

        // R4, R5, R7, R8: Pb over all codes
        for (int y = 0; y < 256; y += 17)
            for (int pb = 0; pb < 256; pb++)
                step(y, pb, (pb * 53 + 3 * y) % 256, 1'b0, 3'(pb ^ y), "R7 pb sweep");

        // R8 rails
        step(255, 128, 255, 1'b0, 3'b101, "R8 red high");
        step(0,   128, 0,   1'b0, 3'b010, "R8 red low");
        step(0,   0,   128, 1'b0, 3'b001, "R8 blue low");
        step(255, 255, 128, 1'b0, 3'b100, "R8 blue high");
        step(0,   255, 255, 1'b0, 3'b011, "R8 green low");
        step(255, 0,   0,   1'b0, 3'b110, "R8 green high");
        // R7 rounding corners
        step(0,   128, 129, 1'b0, 3'b000, "R7 small positive");
        step(10,  127, 127, 1'b0, 3'b111, "R7 negative terms");

        // R9: bypass sweep, then bypass toggling every pixel
        for (int i = 0; i < 256; i++)
            step(i, 255 - i, (i * 7) % 256, 1'b1, 3'(i), "R9 bypass sweep");
        for (int i = 0; i < 256; i++)
            step((i * 11) % 256, (i * 29) % 256, (i * 5 + 1) % 256, i[0], 3'(i >> 1), "R9 toggle");
        flush();

        // R10: mid-stream reset clears pipeline
        step(250, 20, 240, 1'b0, 3'b111, "pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        h0_v = 1'b0; h1_v = 1'b0;
        @(negedge clk);
        check({out_r, out_g, out_b} == 24'd0, "R10 pixel after reset", {out_r, out_g, out_b}, 0);
        check({out_de, out_hs, out_vs} == 3'd0, "R10 sideband after reset", {out_de, out_hs, out_vs}, 0);
        rst_n = 1'b1;
        step(128, 128, 128, 1'b0, 3'b100, "R6 post reset");
        flush();

        summary();
    end
endmodule